// File: doc/BRIEF.md
# Mode-Dependent Port Direction Controller

This block runs a four-pin I/O port whose direction register changes meaning with a static operating mode. In the address-bus modes every pin drives one low address bit and the direction register is locked. In the mixed mode a set direction bit turns its pin into an address output, and a clear bit leaves it as an input. In the single-chip mode a set bit makes the pin a general-purpose output driven from a four-bit port data register.

The CPU reaches two registers through a one-bit select, a write strobe and a combinational read path. The direction register is write-only: reads of it always return all ones. The data register reads back its own bit for output pins and the synchronized pin level for input pins. Reset and hardware standby reload the direction register with a mode-dependent value. Software standby freezes the pins and the registers.

The mode code is sampled only while reset is asserted. The 3-bit codes are grouped as follows: 1 to 4 are the address-bus modes, 5 is the mixed mode, and 7, 0 and 6 are the single-chip mode.

Top module: `port_dir_ctrl`

## Requirements
- R1: A read with `reg_sel`=0 (direction register) returns 8'hFF in every mode, whatever was written before.
- R2: With mode code 1, 2, 3 or 4 latched, `pin_oe` is 4'hF, `pin_out` follows `abus_lo` one cycle later, and direction writes have no effect.
- R3: With mode code 5 latched, a pin whose direction bit is 1 has `pin_oe`=1 and drives its `abus_lo` bit. A pin whose bit is 0 has `pin_oe`=0.
- R4: With mode code 7, 0 or 6 latched, a pin whose direction bit is 1 has `pin_oe`=1 and drives its data-register bit. A pin whose bit is 0 has `pin_oe`=0.
- R5: Reset loads the direction register with 8'hFF in modes 1 to 4 and with 8'hF0 otherwise, and clears the data register. During reset `pin_oe` is 0.
- R6: One cycle of `hw_stby` reloads the direction register as R5 does, using the latched mode. The data register keeps its value.
- R7: While `sw_stby` is high, `pin_oe` and `pin_out` hold their last values, even when `abus_lo` changes, and register writes are ignored.
- R8: A read with `reg_sel`=1 returns 1 in bits 7:4. Each bit i of 3:0 is the data-register bit when direction bit i is 1, and otherwise the synchronized level of `pin_in[i]`.
- R9: A change on `pin_in` first shows in the data read after the second rising edge.
- R10: The mode code is taken only while `rst` is high. A change of `mode_code` without a reset has no effect.
- R11: A write lands on the rising edge where `wr_en` is high and is visible in the read at once. `pin_oe` and `pin_out` follow on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hw_stby | input | 1 | Hardware standby, reloads the direction register |
| sw_stby | input | 1 | Software standby, freezes pins and registers |
| mode_code | input | 3 | Operating mode code, sampled during reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 direction, 1 data |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data for `reg_sel` |
| abus_lo | input | 4 | Low address bus bits |
| pin_in | input | 4 | Pad input levels |
| pin_out | output | 4 | Pad output values |
| pin_oe | output | 4 | Pad output enables |

## Verification
The assertions assume that `mode_code` is steady during reset and that `rst` is high from time zero until the first edge. The stimulus meets both conditions by setting the mode before it raises reset. The properties also assume that `hw_stby` and `sw_stby` are never high together for the hold checks. The stimulus never drives both standby inputs at once. All inputs change only on falling edges, so every register sees settled values on the rising edge.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    localparam int PDC_REG_W = 8;
    localparam int PDC_PINS  = 4;
    localparam int PDC_SYNC  = 2;

    localparam logic SEL_DIR  = 1'b0;
    localparam logic SEL_DATA = 1'b1;

    typedef enum logic [1:0] {
        MC_ABUS   = 2'd0,
        MC_MIXED  = 2'd1,
        MC_SINGLE = 2'd2
    } mode_cls_e;

    typedef struct packed {
        logic oe;
        logic out;
    } pin_drive_t;

    function automatic mode_cls_e decode_mode(input logic [2:0] code);
        mode_cls_e c;
        case (code)
            3'd1, 3'd2, 3'd3, 3'd4: c = MC_ABUS;
            3'd5:                   c = MC_MIXED;
            default:                c = MC_SINGLE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pdc_mode_latch.sv
module pdc_mode_latch
    import pdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] mode_code,
    output mode_cls_e  mode_cls
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_cls <= decode_mode(mode_code);
        end
    end

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(mode_cls)); // R10

endmodule

// File: rtl/pdc_regs.sv
module pdc_regs
    import pdc_pkg::*;
#(
    parameter int REG_W = PDC_REG_W,
    parameter int PINS  = PDC_PINS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hw_stby,
    input  logic             sw_stby,
    input  logic [2:0]       mode_code,
    input  mode_cls_e        mode_cls,
    input  logic             wr_en,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] dir_q,
    output logic [PINS-1:0]  data_q
);

    localparam int RSVD_W = REG_W - PINS;
    localparam logic [REG_W-1:0] INIT_ALL_OUT = '1;
    localparam logic [REG_W-1:0] INIT_ALL_IN  = {{RSVD_W{1'b1}}, {PINS{1'b0}}};

    mode_cls_e        init_cls;
    logic [REG_W-1:0] init_val;
    logic             wr_ok;

    always_comb begin
        init_cls = rst ? decode_mode(mode_code) : mode_cls;
        init_val = (init_cls == MC_ABUS) ? INIT_ALL_OUT : INIT_ALL_IN;
        wr_ok    = wr_en && !hw_stby && !sw_stby;
    end

    always_ff @(posedge clk) begin
        if (rst || hw_stby) begin
            dir_q <= init_val;
        end else if (wr_ok && reg_sel == SEL_DIR && mode_cls != MC_ABUS) begin
            dir_q <= {{RSVD_W{1'b1}}, wr_data[PINS-1:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (wr_ok && reg_sel == SEL_DATA) begin
            data_q <= wr_data[PINS-1:0];
        end
    end

    AST_ABUS_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (mode_cls == MC_ABUS) |-> (dir_q == INIT_ALL_OUT)); // R2

    AST_HW_INIT: assert property (@(posedge clk) disable iff (rst)
        hw_stby |=> (dir_q == ((mode_cls == MC_ABUS) ? INIT_ALL_OUT : INIT_ALL_IN))); // R6

    AST_DIR_WRITE_LAND: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !hw_stby && !sw_stby && reg_sel == SEL_DIR && mode_cls != MC_ABUS)
        |=> (dir_q[PINS-1:0] == $past(wr_data[PINS-1:0]))); // R11

    AST_REGS_SW_HOLD: assert property (@(posedge clk) disable iff (rst)
        (sw_stby && !hw_stby) |=> ($stable(dir_q) && $stable(data_q))); // R7

endmodule

// File: rtl/pdc_sync.sv
module pdc_sync
    import pdc_pkg::*;
#(
    parameter int PINS   = PDC_PINS,
    parameter int STAGES = PDC_SYNC
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PINS-1:0] d_in,
    output logic [PINS-1:0] d_sync
);

    logic [PINS-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            chain[0] <= '0;
        end else begin
            chain[0] <= d_in;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                chain[s] <= '0;
            end else begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign d_sync = chain[STAGES-1];

endmodule

// File: rtl/pdc_pin_drive.sv
module pdc_pin_drive
    import pdc_pkg::*;
#(
    parameter int PINS = PDC_PINS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sw_stby,
    input  mode_cls_e       mode_cls,
    input  logic [PINS-1:0] dir_lo,
    input  logic [PINS-1:0] data_q,
    input  logic [PINS-1:0] abus_lo,
    output logic [PINS-1:0] pin_oe,
    output logic [PINS-1:0] pin_out
);

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        pin_drive_t nxt;
        pin_drive_t cur;

        always_comb begin
            case (mode_cls)
                MC_ABUS:  nxt = '{oe: 1'b1,      out: abus_lo[i]};
                MC_MIXED: nxt = '{oe: dir_lo[i], out: abus_lo[i]};
                default:  nxt = '{oe: dir_lo[i], out: data_q[i]};
            endcase
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                cur <= '{oe: 1'b0, out: 1'b0};
            end else if (!sw_stby) begin
                cur <= nxt;
            end
        end

        assign pin_oe[i]  = cur.oe;
        assign pin_out[i] = cur.out;

        AST_SINGLE_OE: assert property (@(posedge clk) disable iff (rst)
            ($past(!rst && !sw_stby) && mode_cls == MC_SINGLE)
            |-> (pin_oe[i] == $past(dir_lo[i]) && pin_out[i] == $past(data_q[i]))); // R4

        AST_MIXED_OUT: assert property (@(posedge clk) disable iff (rst)
            ($past(!rst && !sw_stby) && mode_cls == MC_MIXED)
            |-> (pin_oe[i] == $past(dir_lo[i]) && pin_out[i] == $past(abus_lo[i]))); // R3

        AST_ABUS_ALL_OUT: assert property (@(posedge clk) disable iff (rst)
            ($past(!rst && !sw_stby) && mode_cls == MC_ABUS)
            |-> (pin_oe[i] && pin_out[i] == $past(abus_lo[i]))); // R2

        AST_SWSTBY_HOLD: assert property (@(posedge clk) disable iff (rst)
            sw_stby |=> ($stable(pin_oe[i]) && $stable(pin_out[i]))); // R7
    end

endmodule

// File: rtl/port_dir_ctrl.sv
module port_dir_ctrl
    import pdc_pkg::*;
#(
    parameter int REG_W  = PDC_REG_W,
    parameter int PINS   = PDC_PINS,
    parameter int STAGES = PDC_SYNC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hw_stby,
    input  logic             sw_stby,
    input  logic [2:0]       mode_code,
    input  logic             wr_en,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic [PINS-1:0]  abus_lo,
    input  logic [PINS-1:0]  pin_in,
    output logic [PINS-1:0]  pin_out,
    output logic [PINS-1:0]  pin_oe
);

    localparam int RSVD_W = REG_W - PINS;

    mode_cls_e        mode_cls;
    logic [REG_W-1:0] dir_q;
    logic [PINS-1:0]  data_q;
    logic [PINS-1:0]  pin_sync;
    logic [PINS-1:0]  data_view;

    pdc_mode_latch u_mode (
        .clk       (clk),
        .rst       (rst),
        .mode_code (mode_code),
        .mode_cls  (mode_cls)
    );

    pdc_regs #(.REG_W(REG_W), .PINS(PINS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .hw_stby   (hw_stby),
        .sw_stby   (sw_stby),
        .mode_code (mode_code),
        .mode_cls  (mode_cls),
        .wr_en     (wr_en),
        .reg_sel   (reg_sel),
        .wr_data   (wr_data),
        .dir_q     (dir_q),
        .data_q    (data_q)
    );

    pdc_sync #(.PINS(PINS), .STAGES(STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d_in   (pin_in),
        .d_sync (pin_sync)
    );

    pdc_pin_drive #(.PINS(PINS)) u_drive (
        .clk      (clk),
        .rst      (rst),
        .sw_stby  (sw_stby),
        .mode_cls (mode_cls),
        .dir_lo   (dir_q[PINS-1:0]),
        .data_q   (data_q),
        .abus_lo  (abus_lo),
        .pin_oe   (pin_oe),
        .pin_out  (pin_out)
    );

    always_comb begin
        data_view = (dir_q[PINS-1:0] & data_q) | (~dir_q[PINS-1:0] & pin_sync);
        if (reg_sel == SEL_DIR) begin
            rd_data = '1;
        end else begin
            rd_data = {{RSVD_W{1'b1}}, data_view};
        end
    end

    AST_RESET_PINS_OFF: assert property (@(posedge clk)
        rst |=> (pin_oe == '0)); // R5

endmodule

// File: tb/sim_port_dir_ctrl.sv
module sim_port_dir_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hw_stby = 1'b0;
    logic       sw_stby = 1'b0;
    logic [2:0] mode_code = 3'd7;
    logic       wr_en = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [3:0] abus_lo = 4'h0;
    logic [3:0] pin_in = 4'h0;
    logic [3:0] pin_out;
    logic [3:0] pin_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    port_dir_ctrl u0 (
        .clk       (clk),
        .rst       (rst),
        .hw_stby   (hw_stby),
        .sw_stby   (sw_stby),
        .mode_code (mode_code),
        .wr_en     (wr_en),
        .reg_sel   (reg_sel),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .abus_lo   (abus_lo),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    typedef struct packed {
        logic [2:0] mode;
        logic [3:0] dir;
        logic [3:0] dat;
        logic [3:0] ab;
        logic [3:0] pins;
        logic [3:0] oe;
        logic [3:0] out;
        logic [7:0] rd;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{3'd7, 4'b0101, 4'b0011, 4'b1111, 4'b1010, 4'b0101, 4'b0011, 8'hFB},
        '{3'd5, 4'b0101, 4'b0011, 4'b1100, 4'b1010, 4'b0101, 4'b1100, 8'hFB},
        '{3'd2, 4'b0000, 4'b0110, 4'b1001, 4'b0000, 4'b1111, 4'b1001, 8'hF6},
        '{3'd0, 4'b1111, 4'b1001, 4'b0000, 4'b0101, 4'b1111, 4'b1001, 8'hF9},
        '{3'd6, 4'b0000, 4'b1111, 4'b1111, 4'b0110, 4'b0000, 4'b1111, 8'hF6},
        '{3'd4, 4'b1010, 4'b0001, 4'b0110, 4'b1111, 4'b1111, 4'b0110, 8'hF1},
        '{3'd1, 4'b0000, 4'b0000, 4'b0101, 4'b0000, 4'b1111, 4'b0101, 8'hF0}
    };

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [2:0] m);
        mode_code = m;
        rst = 1'b1;
        wait_n(2);
        rst = 1'b0;
    endtask

    task automatic reg_write(input logic sel, input logic [7:0] d);
        reg_sel = sel;
        wr_data = d;
        wr_en = 1'b1;
        wait_n(1);
        wr_en = 1'b0;
    endtask

    task automatic read_dir(input string req);
        reg_sel = 1'b0;
        #1;
        check(req, "dir read", rd_data, 8'hFF);
    endtask

    task automatic read_data(input string req, input logic [7:0] exp);
        reg_sel = 1'b1;
        #1;
        check(req, "data read", rd_data, exp);
    endtask

    initial begin
        wait_n(1);

        // Vector table walk: R2 R3 R4 R8 R1
        for (int v = 0; v < NV; v++) begin
            pin_in = VECS[v].pins;
            abus_lo = VECS[v].ab;
            do_reset(VECS[v].mode);
            reg_write(1'b0, {4'h0, VECS[v].dir});
            reg_write(1'b1, {4'hA, VECS[v].dat});
            wait_n(4);
            check("R2/R3/R4", "pin_oe", {4'h0, pin_oe}, {4'h0, VECS[v].oe});
            check("R2/R3/R4", "pin_out", {4'h0, pin_out}, {4'h0, VECS[v].out});
            read_data("R8", VECS[v].rd);
            read_dir("R1");
        end

        // R5: reset state in single-chip mode
        pin_in = 4'h0;
        abus_lo = 4'h0;
        mode_code = 3'd7;
        rst = 1'b1;
        wait_n(2);
        check("R5", "oe in reset", {4'h0, pin_oe}, 8'h00);
        rst = 1'b0;
        wait_n(3);
        check("R5", "oe after reset mode 7", {4'h0, pin_oe}, 8'h00);
        read_data("R5", 8'hF0);

        // R5: data register cleared by reset, address mode pins all out
        reg_write(1'b1, 8'h0F);
        do_reset(3'd3);
        wait_n(2);
        check("R5", "oe after reset mode 3", {4'h0, pin_oe}, 8'h0F);
        read_data("R5", 8'hF0);

        // R11: write lands on its edge, outputs one edge later
        do_reset(3'd7);
        pin_in = 4'b0001;
        wait_n(3);
        read_data("R11", 8'hF1);
        reg_sel = 1'b0;
        wr_data = 8'h01;
        wr_en = 1'b1;
        wait_n(1);
        wr_en = 1'b0;
        check("R11", "oe before follow edge", {4'h0, pin_oe}, 8'h00);
        read_data("R11", 8'hF0);
        wait_n(1);
        check("R11", "oe after follow edge", {4'h0, pin_oe}, 8'h01);

        // R9: two-flop synchronizer latency
        do_reset(3'd7);
        pin_in = 4'h0;
        wait_n(3);
        reg_sel = 1'b1;
        pin_in = 4'hF;
        wait_n(1);
        read_data("R9", 8'hF0);
        wait_n(1);
        read_data("R9", 8'hFF);

        // R10: mode change without reset is ignored
        do_reset(3'd7);
        wait_n(2);
        mode_code = 3'd2;
        wait_n(3);
        check("R10", "oe after mode change", {4'h0, pin_oe}, 8'h00);
        reg_write(1'b0, 8'h03);
        wait_n(2);
        check("R10", "dir write still active", {4'h0, pin_oe}, 8'h03);

        // R7: software standby in single-chip mode
        do_reset(3'd7);
        reg_write(1'b0, 8'h0F);
        reg_write(1'b1, 8'h0A);
        wait_n(2);
        check("R7", "out before standby", {4'h0, pin_out}, 8'h0A);
        sw_stby = 1'b1;
        reg_write(1'b1, 8'h05);
        reg_write(1'b0, 8'h00);
        wait_n(2);
        check("R7", "out held", {4'h0, pin_out}, 8'h0A);
        check("R7", "oe held", {4'h0, pin_oe}, 8'h0F);
        sw_stby = 1'b0;
        wait_n(2);
        check("R7", "data write ignored", {4'h0, pin_out}, 8'h0A);
        check("R7", "dir write ignored", {4'h0, pin_oe}, 8'h0F);

        // R7: software standby freezes address outputs in mixed mode
        do_reset(3'd5);
        abus_lo = 4'h3;
        reg_write(1'b0, 8'h0F);
        wait_n(2);
        check("R7", "mixed out before", {4'h0, pin_out}, 8'h03);
        sw_stby = 1'b1;
        abus_lo = 4'hC;
        wait_n(2);
        check("R7", "mixed out held", {4'h0, pin_out}, 8'h03);
        sw_stby = 1'b0;
        wait_n(2);
        check("R3", "mixed out follows", {4'h0, pin_out}, 8'h0C);

        // R6: hardware standby reloads direction, keeps data
        do_reset(3'd7);
        reg_write(1'b0, 8'h0F);
        reg_write(1'b1, 8'h05);
        wait_n(2);
        check("R6", "oe before hw standby", {4'h0, pin_oe}, 8'h0F);
        hw_stby = 1'b1;
        wait_n(1);
        hw_stby = 1'b0;
        wait_n(2);
        check("R6", "oe after hw standby mode 7", {4'h0, pin_oe}, 8'h00);
        reg_write(1'b0, 8'h0F);
        wait_n(2);
        check("R6", "data kept", {4'h0, pin_out}, 8'h05);

        do_reset(3'd5);
        reg_write(1'b0, 8'h0F);
        hw_stby = 1'b1;
        wait_n(1);
        hw_stby = 1'b0;
        wait_n(2);
        check("R6", "oe after hw standby mode 5", {4'h0, pin_oe}, 8'h00);

        do_reset(3'd2);
        hw_stby = 1'b1;
        wait_n(1);
        hw_stby = 1'b0;
        wait_n(2);
        check("R6", "oe after hw standby mode 2", {4'h0, pin_oe}, 8'h0F);
        read_dir("R1");

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule